// File: doc/BRIEF.md
# Multiphase Regulator Fault Supervisor

This block supervises a multiphase buck regulator from the digital side. Each phase has its own overcurrent comparator flag and its own PWM cycle strobe. While a phase's flag is high, the block blanks that phase's high-side gate at once, so current is limited cycle by cycle. A counter in each phase samples the flag on every strobe. A run of consecutive flagged cycles long enough to reach the trip count sets a sticky overcurrent latch. That latch tri-states the PWM outputs and asks a companion rail to start a soft shutdown.

The output voltage arrives as a stream of digitized samples. A programmable maximum-VID register, written over a simple bus, sets the overvoltage threshold. The threshold is that register plus a fixed offset, saturated at full scale. Once power-on sequencing reports done, any sample above the threshold sets a sticky overvoltage latch. That latch forces the low-side MOSFETs on and blanks every high-side gate. Both latches clear only on reset. A status code records which fault latched first.

The sample stream uses valid/ready. The block never applies back-pressure: `vs_ready` is high whenever reset is released, and a sample is consumed in every cycle where `vs_valid` is high.

Top module: `vr_fault_supervisor`

## Requirements
- R1: Without an overvoltage latch, `hs_blank[i]` equals `oc_flag[i]` in the same cycle, for each phase.
- R2: The overcurrent latch sets on the clock edge that samples the 15th consecutive strobe of one phase with its flag high. After 14 such strobes it stays clear.
- R3: A strobe sampled with the flag low returns that phase's count to zero. Cycles with no strobe leave the count unchanged, whatever the flag is.
- R4: While the overcurrent latch is set, `ss_req` is high. `pwm_hiz` is also high unless the overvoltage latch is set. Both stay high until reset.
- R5: An accepted sample strictly greater than the maximum-VID register plus 30 codes sets the overvoltage latch. A sample equal to that threshold does not. While the latch is set, `ls_force_on` is high and every `hs_blank` bit is high.
- R6: Samples presented while `por_done` is low never set the overvoltage latch.
- R7: The threshold saturates at the all-ones code. A register value whose sum with 30 would overflow gives a threshold that no sample can exceed.
- R8: When both latches are set, `pwm_hiz` is low and `ls_force_on` is high.
- R9: `first_fault` reads 0 after reset, 1 if the overcurrent latch set first, and 2 if the overvoltage latch set first or both set on the same edge. It does not change again until reset.
- R10: The maximum-VID register resets to parameter `VMAX_RST` (default 100). A write is used for samples from the next clock edge onward.
- R11: After reset, `hs_blank`, `pwm_hiz`, `ls_force_on` and `ss_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| por_done | input | 1 | Power-on sequencing complete; arms overvoltage checking |
| oc_flag | input | NPH | Per-phase overcurrent comparator flag |
| pwm_strobe | input | NPH | Per-phase one-cycle PWM period strobe |
| vs_valid | input | 1 | Output-voltage sample valid |
| vs_ready | output | 1 | Sample ready (high whenever out of reset) |
| vs_data | input | VW | Output-voltage sample, 5 mV per code |
| vmax_wr | input | 1 | Write strobe for the maximum-VID register |
| vmax_wdata | input | VW | Maximum-VID write data, 5 mV per code |
| hs_blank | output | NPH | Per-phase high-side gate blanking |
| pwm_hiz | output | 1 | Tri-state all PWM outputs |
| ls_force_on | output | 1 | Force low-side MOSFETs on |
| ss_req | output | 1 | Soft-shutdown request to companion rail |
| first_fault | output | 2 | First latched fault: 0 none, 1 overcurrent, 2 overvoltage |

## Verification
The overcurrent path is driven with runs of exactly 14 and exactly 15 flagged strobes. It is also driven with a run broken by a single clean strobe, and with idle cycles between strobes while the flag is low. These patterns separate off-by-one trip counts, resets taken on missing strobes, and resets skipped on clean strobes. The overvoltage path is probed at the threshold and one code above it, before and after `por_done`, and at register values near full scale. These probes separate strict from non-strict comparison, missing saturation, and early arming. Combined faults in both orders check output priority and the first-fault code.

// File: rtl/vrfs_pkg.sv
package vrfs_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_OC   = 2'd1,
    FLT_OV   = 2'd2
  } fault_e;
endpackage

// File: rtl/vrfs_phase_counter.sv
module vrfs_phase_counter #(
  parameter int TRIP = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic flag,
  output logic trip
);
  localparam int CW = $clog2(TRIP + 1);
  localparam logic [CW-1:0] LAST = CW'(TRIP - 1);

  logic [CW-1:0] run_cnt;

  assign trip = strobe && flag && (run_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (strobe) begin
      if (!flag)                run_cnt <= '0;
      else if (run_cnt != LAST) run_cnt <= run_cnt + 1'b1;
    end
  end

  a_r3_clean_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !flag) |=> (run_cnt == '0));
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(run_cnt));
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= LAST);
endmodule

// File: rtl/vrfs_ov_monitor.sv
module vrfs_ov_monitor #(
  parameter int VW       = 8,
  parameter int OFS      = 30,
  parameter int VMAX_RST = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_done,
  input  logic          wr_en,
  input  logic [VW-1:0] wr_data,
  input  logic          s_valid,
  input  logic [VW-1:0] s_data,
  output logic          ov_hit
);
  localparam logic [VW:0] OFS_W = (VW+1)'(OFS);

  logic [VW-1:0] vmax_q;
  logic [VW:0]   thr_sum;
  logic [VW-1:0] thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vmax_q <= VW'(VMAX_RST);
    else if (wr_en) vmax_q <= wr_data;
  end

  assign thr_sum = {1'b0, vmax_q} + OFS_W;
  assign thr     = thr_sum[VW] ? {VW{1'b1}} : thr_sum[VW-1:0];
  assign ov_hit  = por_done && s_valid && (s_data > thr);

  a_r7_threshold_floor: assert property (@(posedge clk) disable iff (!rst_n)
    thr >= vmax_q);
  a_r6_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |-> !ov_hit);
endmodule

// File: rtl/vr_fault_supervisor.sv
module vr_fault_supervisor
  import vrfs_pkg::*;
#(
  parameter int NPH      = 4,
  parameter int VW       = 8,
  parameter int TRIP     = 15,
  parameter int OFS      = 30,
  parameter int VMAX_RST = 100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           por_done,
  input  logic [NPH-1:0] oc_flag,
  input  logic [NPH-1:0] pwm_strobe,
  input  logic           vs_valid,
  output logic           vs_ready,
  input  logic [VW-1:0]  vs_data,
  input  logic           vmax_wr,
  input  logic [VW-1:0]  vmax_wdata,
  output logic [NPH-1:0] hs_blank,
  output logic           pwm_hiz,
  output logic           ls_force_on,
  output logic           ss_req,
  output logic [1:0]     first_fault
);
  logic [NPH-1:0] phase_trip;
  logic           ov_hit;
  logic           oc_latch, ov_latch;
  fault_e         first_q;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    vrfs_phase_counter #(.TRIP(TRIP)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (pwm_strobe[p]),
      .flag   (oc_flag[p]),
      .trip   (phase_trip[p])
    );
  end

  vrfs_ov_monitor #(.VW(VW), .OFS(OFS), .VMAX_RST(VMAX_RST)) u_ov (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_done (por_done),
    .wr_en    (vmax_wr),
    .wr_data  (vmax_wdata),
    .s_valid  (vs_valid),
    .s_data   (vs_data),
    .ov_hit   (ov_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_latch <= 1'b0;
      ov_latch <= 1'b0;
      first_q  <= FLT_NONE;
    end else begin
      if (|phase_trip) oc_latch <= 1'b1;
      if (ov_hit)      ov_latch <= 1'b1;
      if (first_q == FLT_NONE) begin
        if (ov_hit)           first_q <= FLT_OV;
        else if (|phase_trip) first_q <= FLT_OC;
      end
    end
  end

  assign vs_ready    = rst_n;
  assign hs_blank    = ov_latch ? {NPH{1'b1}} : oc_flag;
  assign ls_force_on = ov_latch;
  assign pwm_hiz     = oc_latch && !ov_latch;
  assign ss_req      = oc_latch;
  assign first_fault = first_q;

  a_r4_oc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |=> ss_req);
  a_r5_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ls_force_on |=> ls_force_on);
  a_r5_ov_blanks_all: assert property (@(posedge clk) disable iff (!rst_n)
    ls_force_on |-> (&hs_blank));
  a_r8_ov_priority: assert property (@(posedge clk) disable iff (!rst_n)
    ls_force_on |-> !pwm_hiz);
  a_r1_blank_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_force_on |-> (hs_blank == oc_flag));
  a_r9_first_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (first_fault != 2'd0) |=> $stable(first_fault));
  a_r9_first_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_req || ls_force_on) |-> (first_fault != 2'd0));
endmodule

// File: tb/tb_vr_fault_supervisor.sv
module tb_vr_fault_supervisor;
  localparam int NPH = 4;
  localparam int VW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_done = 1'b0;
  logic [NPH-1:0] oc_flag = '0;
  logic [NPH-1:0] pwm_strobe = '0;
  logic vs_valid = 1'b0;
  logic vs_ready;
  logic [VW-1:0] vs_data = '0;
  logic vmax_wr = 1'b0;
  logic [VW-1:0] vmax_wdata = '0;
  logic [NPH-1:0] hs_blank;
  logic pwm_hiz, ls_force_on, ss_req;
  logic [1:0] first_fault;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  vr_fault_supervisor dut (
    .clk(clk), .rst_n(rst_n), .por_done(por_done), .oc_flag(oc_flag),
    .pwm_strobe(pwm_strobe), .vs_valid(vs_valid), .vs_ready(vs_ready),
    .vs_data(vs_data), .vmax_wr(vmax_wr), .vmax_wdata(vmax_wdata),
    .hs_blank(hs_blank), .pwm_hiz(pwm_hiz), .ls_force_on(ls_force_on),
    .ss_req(ss_req), .first_fault(first_fault)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; por_done = 1'b0; oc_flag = '0; pwm_strobe = '0;
    vs_valid = 1'b0; vs_data = '0; vmax_wr = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1; por_done = 1'b1;
    @(negedge clk);
  endtask

  // one strobe on phase p with given flag, then release
  task automatic pulse(input int p, input logic f);
    oc_flag[p] = f; pwm_strobe[p] = 1'b1;
    @(negedge clk);
    pwm_strobe[p] = 1'b0; oc_flag[p] = 1'b0;
  endtask

  task automatic sample(input logic [VW-1:0] v);
    vs_valid = 1'b1; vs_data = v;
    @(negedge clk);
    vs_valid = 1'b0;
  endtask

  task automatic write_vmax(input logic [VW-1:0] v);
    vmax_wr = 1'b1; vmax_wdata = v;
    @(negedge clk);
    vmax_wr = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R11 hs_blank", hs_blank, 0);
    check("R11 pwm_hiz", pwm_hiz, 0);
    check("R11 ls_force_on", ls_force_on, 0);
    check("R11 ss_req", ss_req, 0);
    check("R9 first_fault none", first_fault, 0);
    check("ready high", vs_ready, 1);
  endtask

  task automatic t_blank_follow();
    do_reset();
    oc_flag = 4'b0010; #1;
    check("R1 blank phase1", hs_blank, 4'b0010);
    oc_flag = 4'b1001; #1;
    check("R1 blank phases0,3", hs_blank, 4'b1001);
    oc_flag = '0; #1;
    check("R1 blank released", hs_blank, 0);
  endtask

  task automatic t_oc_count();
    do_reset();
    for (int i = 0; i < 14; i++) pulse(2, 1'b1);
    check("R2 no trip at 14", ss_req, 0);
    pulse(2, 1'b0);
    for (int i = 0; i < 14; i++) begin
      pulse(2, 1'b1);
      oc_flag[2] = 1'b0; @(negedge clk);  // idle cycle, no strobe
    end
    check("R3 clean strobe restarts run", ss_req, 0);
    pulse(2, 1'b1);
    check("R2 trip at 15 across idle cycles", ss_req, 1);
    check("R4 pwm_hiz", pwm_hiz, 1);
    check("R9 first OC", first_fault, 1);
    for (int i = 0; i < 5; i++) @(negedge clk);
    check("R4 oc sticky", pwm_hiz & ss_req, 1);
    check("R4 no low-side force", ls_force_on, 0);
  endtask

  task automatic t_ov_threshold();
    do_reset();
    sample(8'd130);
    check("R10 R5 equal no trip", ls_force_on, 0);
    sample(8'd131);
    check("R10 R5 above trips", ls_force_on, 1);
    check("R5 all blanked", hs_blank, 4'hF);
    check("R9 first OV", first_fault, 2);
    do_reset();
    write_vmax(8'd50);
    sample(8'd81);
    check("R10 new vmax used", ls_force_on, 1);
  endtask

  task automatic t_por();
    do_reset();
    por_done = 1'b0;
    sample(8'd250);
    sample(8'd250);
    check("R6 unarmed no trip", ls_force_on, 0);
    por_done = 1'b1;
    sample(8'd250);
    check("R6 armed trips", ls_force_on, 1);
  endtask

  task automatic t_saturate();
    do_reset();
    write_vmax(8'd240);
    sample(8'd255);
    check("R7 saturated 240", ls_force_on, 0);
    write_vmax(8'd225);
    sample(8'd255);
    check("R7 saturated 225", ls_force_on, 0);
    write_vmax(8'd224);
    sample(8'd255);
    check("R7 224 threshold 254", ls_force_on, 1);
  endtask

  task automatic t_priority();
    do_reset();
    for (int i = 0; i < 15; i++) pulse(0, 1'b1);
    check("R4 oc set", pwm_hiz, 1);
    sample(8'd200);
    check("R8 hiz dropped", pwm_hiz, 0);
    check("R8 ls on", ls_force_on, 1);
    check("R4 ss stays", ss_req, 1);
    check("R9 first stays OC", first_fault, 1);
    do_reset();
    sample(8'd200);
    for (int i = 0; i < 15; i++) pulse(3, 1'b1);
    check("R8 OV then OC hiz low", pwm_hiz, 0);
    check("R9 first stays OV", first_fault, 2);
    check("R4 ss after OV", ss_req, 1);
  endtask

  initial begin
    t_reset_state();
    t_blank_follow();
    t_oc_count();
    t_ov_threshold();
    t_por();
    t_saturate();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule